// File: doc/BRIEF.md
# Flow-Gated Serial Transmitter

This block turns bytes into asynchronous serial frames. Bytes are written into an internal transmit queue. At each bit-period strobe the serialiser either moves to the next bit of the current frame or, when a frame has just ended, decides whether to start the next one. A frame is a low start bit, then 7 or 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The line rests high between frames.

An external active-low clear-to-send input is passed through a two-register synchroniser. It is consulted only at frame boundaries, so a frame that has begun always runs to its last stop bit. The check can be switched off in the configuration word. The baud strobe comes from outside the block.

Top module: `uart_cts_tx`

## Requirements
- R1: After synchronous reset the line output is high, busy is low and the queue-empty flag is high.
- R2: A frame is a 0 start bit, then the data bits with the LSB first, then any parity bit, then the stop bits at 1. Each bit holds for exactly one strobe interval: it starts on the clock edge where `bit_tick` is high and changes only on a later such edge. The line is high whenever busy is low.
- R3: `cfg_word[2]` = 1 sends all 8 bits of a byte. `cfg_word[2]` = 0 sends only bits 6..0.
- R4: `cfg_word[3]` = 1 inserts a parity bit. With `cfg_word[4]` = 0 (even rule) the bit is 1 exactly when the sent data bits hold an odd number of ones. With `cfg_word[4]` = 1 (odd rule) the bit is 1 exactly when they hold an even number of ones.
- R5: `cfg_word[1]` = 0 gives one stop bit. `cfg_word[1]` = 1 gives two stop bits.
- R6: With `cfg_word[0]` = 1, a frame starts at a strobe only when the synchronised `cts_n` is 0. While it is 1, queued bytes are held and the line stays idle.
- R7: If `cts_n` rises during a frame, that frame completes in full and no further frame starts until `cts_n` falls again.
- R8: With `cfg_word[0]` = 0, `cts_n` has no effect and queued bytes are sent whatever its level.
- R9: `cts_n` passes through two registers. A level applied before clock edge k governs start decisions from edge k+2 onwards.
- R10: The queue holds DEPTH bytes (16 by default) and sends them in write order. A write while DEPTH bytes are already held is dropped.
- R11: `fifo_empty` tracks only the queue, so it can be high while a frame is still shifting. Busy stays high until the interval of the last stop bit ends. A queued byte that may start at that same strobe follows with no idle gap.
- R12: The configuration is captured when a frame starts. A change during a frame takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Byte to queue |
| bit_tick | input | 1 | One-cycle pulse per bit interval |
| cfg_word | input | 5 | [0] flow enable, [1] two stops, [2] eight bits, [3] parity enable, [4] odd rule |
| cts_n | input | 1 | Active-low clear-to-send, asynchronous |
| tx_line | output | 1 | Serial output |
| fifo_empty | output | 1 | Queue holds no bytes |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with a queue depth of 4 and the default two-stage synchroniser. The small depth makes overflow drops and wrap-around of the read and write pointers reachable within a few writes. A bit strobe every fourth clock keeps frames short, so many CTS edge offsets relative to the strobe can be swept. These include edges that land in the synchroniser window just before a frame boundary.

// File: rtl/uart_cts_tx_pkg.sv
package uart_cts_tx_pkg;

    localparam int FRAME_MAX = 12;
    localparam int LEN_W     = 4;

    typedef struct packed {
        logic parity_odd;
        logic parity_en;
        logic eight_bits;
        logic two_stop;
        logic flow_en;
    } tx_cfg_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [LEN_W-1:0]     len;
    } frame_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    function automatic logic parity_of(input logic [7:0] d, input tx_cfg_t c);
        logic ones_odd;
        ones_odd = c.eight_bits ? ^d : ^d[6:0];
        return c.parity_odd ? ~ones_odd : ones_odd;
    endfunction

    function automatic frame_t build_frame(input logic [7:0] d, input tx_cfg_t c);
        frame_t f;
        int     pos;
        f.bits    = '1;
        f.bits[0] = 1'b0;
        pos       = 1;
        for (int i = 0; i < 8; i++) begin
            if (i < 7 || c.eight_bits) begin
                f.bits[pos] = d[i];
                pos++;
            end
        end
        if (c.parity_en) begin
            f.bits[pos] = parity_of(d, c);
            pos++;
        end
        f.len = LEN_W'(pos + 1 + (c.two_stop ? 1 : 0));
        return f;
    endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          do_wr, do_rd;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign rd_data = mem[rd_ptr];
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    assert_full_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> full);

endmodule

// File: rtl/uart_cts_sync.sv
module uart_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_cts_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_tick,
    input  tx_cfg_t    cfg,
    input  logic       q_empty,
    input  logic [7:0] q_data,
    input  logic       clear_to_send,
    output logic       pop,
    output logic       tx,
    output logic       busy
);
    tx_state_e            state;
    logic [FRAME_MAX-1:0] shreg;
    logic [LEN_W-1:0]     remain;
    frame_t               next_frame;
    logic                 at_boundary;

    assign busy        = (state == ST_SEND);
    assign at_boundary = (state == ST_IDLE) || (remain == '0);
    assign pop         = bit_tick && at_boundary && !q_empty && clear_to_send;

    always_comb next_frame = build_frame(q_data, cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            tx     <= 1'b1;
            shreg  <= '1;
            remain <= '0;
        end else if (bit_tick) begin
            if (!at_boundary) begin
                tx     <= shreg[0];
                shreg  <= {1'b1, shreg[FRAME_MAX-1:1]};
                remain <= remain - 1'b1;
            end else if (pop) begin
                tx     <= next_frame.bits[0];
                shreg  <= {1'b1, next_frame.bits[FRAME_MAX-1:1]};
                remain <= next_frame.len - 1'b1;
                state  <= ST_SEND;
            end else begin
                tx     <= 1'b1;
                state  <= ST_IDLE;
            end
        end
    end

    assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);

    assert_bit_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(tx));

    assert_busy_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(busy));

endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
    import uart_cts_tx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       bit_tick,
    input  logic [4:0] cfg_word,
    input  logic       cts_n,
    output logic       tx_line,
    output logic       fifo_empty,
    output logic       busy
);
    tx_cfg_t    cfg;
    logic       cts_n_sync;
    logic       clear_to_send;
    logic       pop;
    logic       q_full;
    logic [7:0] q_data;

    assign cfg           = tx_cfg_t'(cfg_word);
    assign clear_to_send = !cfg.flow_en || !cts_n_sync;

    uart_tx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (pop),
        .rd_data (q_data),
        .empty   (fifo_empty),
        .full    (q_full)
    );

    uart_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (cts_n),
        .sync_out (cts_n_sync)
    );

    uart_tx_engine u_engine (
        .clk           (clk),
        .rst           (rst),
        .bit_tick      (bit_tick),
        .cfg           (cfg),
        .q_empty       (fifo_empty),
        .q_data        (q_data),
        .clear_to_send (clear_to_send),
        .pop           (pop),
        .tx            (tx_line),
        .busy          (busy)
    );

    assert_pop_nonempty_R10: assert property (@(posedge clk) disable iff (rst)
        pop |-> !fifo_empty);

    assert_pop_starts_R2: assert property (@(posedge clk) disable iff (rst)
        pop |=> (busy && !tx_line));

    assert_full_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (q_full && !pop) |=> !fifo_empty);

endmodule

// File: tb/uart_cts_tx_tb.sv
module uart_cts_tx_tb;
    localparam int DEPTH = 4;
    localparam int TICK_DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       bit_tick = 1'b0;
    logic [4:0] cfg_word = 5'b00101;
    logic       cts_n = 1'b0;
    logic       tx_line, fifo_empty, busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tcnt = 0;
    string cur_req = "R2";
    bit done = 0;

    uart_cts_tx #(.DEPTH(DEPTH), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .bit_tick(bit_tick), .cfg_word(cfg_word), .cts_n(cts_n),
        .tx_line(tx_line), .fifo_empty(fifo_empty), .busy(busy)
    );

    always #2 clk = ~clk;

    // reference model
    logic [7:0] mq[$];
    bit         fb[$];
    bit         m_tx = 1, m_busy = 0, s1 = 1, s2 = 1;

    always @(posedge clk) begin
        if (rst) begin
            mq.delete(); fb.delete();
            m_tx = 1; m_busy = 0; s1 = 1; s2 = 1;
        end else begin
            bit full0, may_start;
            full0 = (mq.size() >= DEPTH);
            may_start = bit_tick && mq.size() > 0 && (!cfg_word[0] || !s2) &&
                        (!m_busy || fb.size() == 0);
            if (bit_tick) begin
                if (m_busy && fb.size() > 0) begin
                    m_tx = fb.pop_front();
                end else if (may_start) begin
                    logic [7:0] d;
                    int nb, ones;
                    d = mq.pop_front();
                    nb = cfg_word[2] ? 8 : 7;
                    ones = 0;
                    fb.push_back(0);
                    for (int i = 0; i < nb; i++) begin
                        fb.push_back(d[i]);
                        ones += d[i];
                    end
                    if (cfg_word[3]) fb.push_back(cfg_word[4] ? ((ones % 2) == 0) : ((ones % 2) == 1));
                    fb.push_back(1);
                    if (cfg_word[1]) fb.push_back(1);
                    m_tx = fb.pop_front();
                    m_busy = 1;
                end else begin
                    m_tx = 1; m_busy = 0;
                end
            end
            if (wr_en && !full0) mq.push_back(wr_data);
            s2 = s1; s1 = cts_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // strobe generator and per-cycle comparison
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            tcnt = 0; bit_tick = 0;
        end else begin
            check(tx_line === m_tx, cur_req, tx_line, m_tx, "line");
            check(busy === m_busy, "R11", busy, m_busy, "busy");
            check(fifo_empty === (mq.size() == 0), "R11", fifo_empty, mq.size() == 0, "empty");
            tcnt = (tcnt + 1) % TICK_DIV;
            bit_tick = (tcnt == 0);
        end
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic put(input logic [7:0] b);
        @(negedge clk); wr_en = 1; wr_data = b;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        int n = 0;
        while ((m_busy || mq.size() != 0) && n < 20000) begin
            @(negedge clk); n++;
        end
        idle(3);
    endtask

    task automatic wait_busy();
        int n = 0;
        while (!m_busy && n < 1000) begin
            @(negedge clk); n++;
        end
    endtask

    initial begin
        idle(3);
        check(tx_line === 1'b1, "R1", tx_line, 1, "reset line");
        check(busy === 1'b0, "R1", busy, 0, "reset busy");
        check(fifo_empty === 1'b1, "R1", fifo_empty, 1, "reset empty");
        @(negedge clk); rst = 0;
        idle(5);

        // R2/R11: 8N1, back-to-back
        cur_req = "R2"; cfg_word = 5'b00101; cts_n = 0;
        put(8'hA5); put(8'h3C); put(8'h01);
        drain();

        // R3/R4/R5: 7 bits, even parity, two stops
        cur_req = "R3"; cfg_word = 5'b01011;
        put(8'hFF); put(8'h80); put(8'h55);
        drain();

        // R4: odd parity, 8 bits
        cur_req = "R4"; cfg_word = 5'b11101;
        put(8'h00); put(8'h07); put(8'hF0);
        drain();

        // R5: 8 bits, no parity, two stops
        cur_req = "R5"; cfg_word = 5'b00111;
        put(8'h6B);
        drain();

        // R6: hold while cts high
        cur_req = "R6"; cfg_word = 5'b00101; cts_n = 1;
        idle(4);
        put(8'h12); put(8'h34);
        idle(100);
        check(busy === 1'b0, "R6", busy, 0, "held busy");
        check(tx_line === 1'b1, "R6", tx_line, 1, "held line");
        check(fifo_empty === 1'b0, "R6", fifo_empty, 0, "held queue");
        cts_n = 0;
        drain();

        // R7: cts rises mid-frame
        cur_req = "R7";
        put(8'h9A); put(8'hBC); put(8'hDE);
        wait_busy(); idle(10);
        cts_n = 1;
        idle(300);
        check(busy === 1'b0, "R7", busy, 0, "stopped busy");
        check(fifo_empty === 1'b0, "R7", fifo_empty, 0, "remaining queue");
        cts_n = 0;
        drain();

        // R8: flow control off
        cur_req = "R8"; cfg_word = 5'b00100; cts_n = 1;
        put(8'hC3); put(8'h5A);
        idle(30);
        check(busy === 1'b1, "R8", busy, 1, "sending despite cts");
        drain();
        cfg_word = 5'b00101;

        // R9: cts pulses at swept offsets
        cur_req = "R9";
        for (int k = 0; k < 8; k++) begin
            cts_n = 1; put(8'(8'h40 + k));
            idle(k);
            cts_n = 0; idle(2 + (k % 3)); cts_n = 1;
            idle(60);
            cts_n = 0;
            drain();
        end

        // R10: overflow drop with small depth
        cur_req = "R10"; cts_n = 1;
        idle(4);
        for (int i = 0; i < DEPTH + 2; i++) put(8'(8'h70 + i));
        check(fifo_empty === 1'b0, "R10", fifo_empty, 0, "queue filled");
        idle(20);
        cts_n = 0;
        drain();
        check(fifo_empty === 1'b1, "R10", fifo_empty, 1, "drained");

        // R12: configuration change mid-frame
        cur_req = "R12"; cfg_word = 5'b00101;
        put(8'hE7); put(8'h18);
        wait_busy(); idle(5);
        cfg_word = 5'b11011;
        drain();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule